// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block sits at the input of a display controller and decides what the incoming 32-bit word stream means. A two-bit load mode, sampled when the block is enabled, selects one of three jobs. The block can fill a colour lookup table from the stream and then stop. It can treat the stream as pixel data from the start. Or it can fill the table first and then move on to pixels. The 16-bit entry that arrives first in the table carries a depth code, which fixes how many entries the table holds and how later pixel words are unpacked.

Once the table is full, the block raises a loaded status and an interrupt. In pixel mode the panel side pulls one pixel per request. Pixel words are unpacked into four palette-expanded 12-bit colours when the depth code selects 8 bits per pixel, and into two raw 16-bit halves otherwise. An unknown depth code stops the load with an error flag. A request that finds no pixel buffered sets a sticky underflow flag. Dropping the enable returns the block to idle and clears all status.

Top module: `pal_frame_seq`

## Requirements
- R1: While reset is held, `in_ready`, `pix_valid`, `sts_loaded`, `sts_err`, `sts_und` and `irq` are all 0.
- R2: The mode is sampled while idle and enabled: 2'b01 loads the table only, 2'b10 accepts pixel words only, 2'b00 loads the table and then accepts pixel words, and 2'b11 leaves `in_ready` low.
- R3: Bits [14:12] of the first table entry are the depth code. Code 3 gives 256 entries (128 words), code 4 gives 16 entries (8 words), and codes 0, 1 and 2 give 128 entries (64 words). `sts_loaded` rises in the cycle after the last table word is accepted and not earlier.
- R4: A depth code of 5, 6 or 7 sets `sts_err`, keeps `sts_loaded` at 0 and holds `in_ready` low until the block is disabled.
- R5: Each table word holds two entries, with bits [15:0] going to the lower index first. Each entry's colour is bits [11:0] (red [11:8], green [7:4], blue [3:0]), and its upper bits are not stored.
- R6: With depth code 3 latched, each pixel word yields four pixels, byte [7:0] first. Each pixel is `{4'b0, table[byte]}`.
- R7: With any other latched depth code, each pixel word yields two pixels, bits [15:0] first, passed through unchanged and independent of the table. After reset the latched code is 4.
- R8: `pix_valid` is high for one cycle, one cycle after a cycle in which `pix_req` was high and a pixel was buffered.
- R9: Pulsing `clr_loaded` clears `sts_loaded` only when the sampled mode is 2'b01. In the other modes it has no effect.
- R10: Driving `ctl_en` low returns the block to idle, with `in_ready` low and `sts_loaded`, `sts_err` and `sts_und` cleared, one cycle later.
- R11: `pix_req` in the pixel phase with no pixel buffered sets `sts_und`, which stays set until disable.
- R12: `irq` is high exactly while `sts_loaded` or `sts_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Block enable; low forces idle and clears status |
| ctl_mode | input | 2 | Load mode, sampled on start |
| clr_loaded | input | 1 | Write-one-to-clear pulse for the loaded status |
| in_data | input | 32 | Stream word |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with `in_valid` |
| pix_req | input | 1 | Panel-side request for one pixel |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | 16 | Pixel: expanded colour or raw 16-bit value |
| sts_loaded | output | 1 | Table fully received |
| sts_err | output | 1 | Unknown depth code seen |
| sts_und | output | 1 | Pixel requested with none buffered |
| irq | output | 1 | Interrupt level |

## Verification
The properties assume that `pix_req` is driven only as a request and that `clr_loaded` is a plain pulse. They also assume the mode does not need to stay stable after the start, since the block keeps its own copy. The bench holds `pix_req` low until the first pixel word has been taken. It then asserts `pix_req` for exactly as many cycles as the queued words hold pixels, while the next word is already valid, so underflow arises only in the one test that provokes it on purpose. All stream and control inputs change on the falling clock edge.

// File: rtl/pal_frame_seq.sv
module pal_frame_seq #(
  parameter int PIX_W   = 16,
  parameter int COLOR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic [1:0]       ctl_mode,
  input  logic             clr_loaded,
  input  logic [31:0]      in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             pix_req,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             sts_loaded,
  output logic             sts_err,
  output logic             sts_und,
  output logic             irq
);
  localparam int ENTRIES = 256;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef enum logic [2:0] {S_IDLE, S_PAL, S_FRAME, S_DONE, S_HALT} st_t;

  st_t              st;
  logic [1:0]       mode_q;
  logic [2:0]       depth_q;
  logic [IDX_W-1:0] wcnt, wlast;
  logic [31:0]      wbuf;
  logic [2:0]       rem;
  logic [1:0]       pos;
  logic [COLOR_W-1:0] pal [ENTRIES];

  function automatic logic [IDX_W-1:0] last_word(input logic [2:0] code);
    case (code)
      3'd3:    return IDX_W'(127);
      3'd4:    return IDX_W'(7);
      default: return IDX_W'(63);
    endcase
  endfunction

  wire [2:0] new_code = in_data[14:12];
  wire       bad_code = new_code > 3'd4;
  wire       first_w  = (wcnt == '0);
  wire       idx8     = (depth_q == 3'd3);
  wire [2:0] ppw      = idx8 ? 3'd4 : 3'd2;

  assign in_ready = (st == S_PAL) ||
                    (st == S_FRAME && (rem == 3'd0 || (rem == 3'd1 && pix_req)));

  wire pal_acc = (st == S_PAL) && in_valid;
  wire push    = (st == S_FRAME) && in_valid && in_ready;
  wire pop     = (st == S_FRAME) && pix_req && (rem != 3'd0);

  wire [7:0]       sel_byte = wbuf[{pos, 3'b000} +: 8];
  wire [PIX_W-1:0] px_pal   = PIX_W'(pal[sel_byte]);
  wire [PIX_W-1:0] px_raw   = pos[0] ? wbuf[31:16] : wbuf[15:0];
  wire [PIX_W-1:0] px       = idx8 ? px_pal : px_raw;

  wire [IDX_W-1:0] wr_idx = {wcnt[IDX_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (pal_acc && !(first_w && bad_code)) begin
      pal[wr_idx]         <= in_data[COLOR_W-1:0];
      pal[wr_idx | 8'd1]  <= in_data[16 +: COLOR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= 2'b00;
      depth_q    <= 3'd4;
      wcnt       <= '0;
      wlast      <= '0;
      wbuf       <= '0;
      rem        <= '0;
      pos        <= '0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      sts_loaded <= 1'b0;
      sts_err    <= 1'b0;
      sts_und    <= 1'b0;
    end else if (!ctl_en) begin
      st         <= S_IDLE;
      wcnt       <= '0;
      rem        <= '0;
      pos        <= '0;
      pix_valid  <= 1'b0;
      sts_loaded <= 1'b0;
      sts_err    <= 1'b0;
      sts_und    <= 1'b0;
    end else begin
      pix_valid <= pop;
      if (clr_loaded && mode_q == 2'b01) sts_loaded <= 1'b0;
      case (st)
        S_IDLE: begin
          mode_q <= ctl_mode;
          wcnt   <= '0;
          rem    <= '0;
          if (ctl_mode == 2'b01 || ctl_mode == 2'b00) st <= S_PAL;
          else if (ctl_mode == 2'b10)                 st <= S_FRAME;
        end
        S_PAL: if (in_valid) begin
          if (first_w) begin
            if (bad_code) begin
              sts_err <= 1'b1;
              st      <= S_HALT;
            end else begin
              depth_q <= new_code;
              wlast   <= last_word(new_code);
              wcnt    <= IDX_W'(1);
            end
          end else if (wcnt == wlast) begin
            sts_loaded <= 1'b1;
            rem        <= '0;
            st         <= (mode_q == 2'b01) ? S_DONE : S_FRAME;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_FRAME: begin
          if (pix_req && rem == 3'd0) sts_und <= 1'b1;
          if (pop) begin
            pix_data <= px;
            pos      <= pos + 1'b1;
            rem      <= rem - 1'b1;
          end
          if (push) begin
            wbuf <= in_data;
            pos  <= '0;
            rem  <= ppw;
          end
        end
        default: ;
      endcase
    end
  end

  assign irq = sts_loaded | sts_err;
endmodule

// File: rtl/pal_frame_seq_chk.sv
module pal_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_en,
  input logic clr_loaded,
  input logic in_ready,
  input logic pix_req,
  input logic pix_valid,
  input logic sts_loaded,
  input logic sts_err,
  input logic sts_und
);
  AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !in_ready); // R10
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (!sts_loaded && !sts_err && !sts_und)); // R10
  AST_ERR_NOT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_err && sts_loaded)); // R4
  AST_ERR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_err |-> !in_ready); // R4
  AST_PIX_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pix_req)); // R8
  AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_und && ctl_en) |=> sts_und); // R11
  AST_LOADED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_loaded && ctl_en && !clr_loaded) |=> sts_loaded); // R9
endmodule

bind pal_frame_seq pal_frame_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .clr_loaded(clr_loaded),
  .in_ready(in_ready), .pix_req(pix_req), .pix_valid(pix_valid),
  .sts_loaded(sts_loaded), .sts_err(sts_err), .sts_und(sts_und)
);

// File: tb/pal_frame_seq_tb_top.sv
`timescale 1ns/1ps
module pal_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0;
  logic [1:0]  ctl_mode = 2'b00;
  logic        clr_loaded = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        pix_req = 1'b0;
  logic        pix_valid;
  logic [15:0] pix_data;
  logic        sts_loaded, sts_err, sts_und, irq;

  int checks = 0;
  int errors = 0;
  bit first_acc = 0;
  logic [11:0] mpal [256];
  logic [15:0] expq [$];

  always #2.5 clk = ~clk;

  pal_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
    .clr_loaded(clr_loaded), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .pix_req(pix_req), .pix_valid(pix_valid),
    .pix_data(pix_data), .sts_loaded(sts_loaded), .sts_err(sts_err),
    .sts_und(sts_und), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (pix_valid) begin
      if (expq.size() == 0) check("R8 unexpected pixel", {16'h0, pix_data}, 32'hdead);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check("R6/R7 pixel", {16'h0, pix_data}, {16'h0, e});
      end
    end
  end

  function automatic logic [11:0] colr(input int k, input int seed);
    return 12'((k * 37 + seed) & 12'hfff);
  endfunction

  // called at a falling edge, returns at a falling edge
  task automatic send_word(input logic [31:0] w);
    in_data = w; in_valid = 1'b1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    first_acc = 1;
  endtask

  task automatic restart(input logic [1:0] m);
    @(negedge clk); ctl_en = 1'b0;
    @(negedge clk); ctl_mode = m; ctl_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_pal(input logic [2:0] code, input int seed, input int nwords, input string req);
    for (int i = 0; i < nwords; i++) begin
      logic [15:0] lo, hi;
      mpal[2*i]   = colr(2*i, seed);
      mpal[2*i+1] = colr(2*i+1, seed);
      lo = (i == 0) ? {1'b0, code, mpal[0]} : {4'ha, mpal[2*i]};
      hi = {4'h5, mpal[2*i+1]};
      if (i == nwords - 1) check({req, " loaded before last word"}, {31'b0, sts_loaded}, 0);
      send_word({hi, lo});
    end
    check({req, " loaded after last word"}, {31'b0, sts_loaded}, 1);
    check("R12 irq with loaded", {31'b0, irq}, 1);
  endtask

  task automatic stream(input logic [31:0] words [$], input bit idx8);
    int n;
    foreach (words[i]) begin
      if (idx8) for (int b = 0; b < 4; b++) expq.push_back({4'h0, mpal[words[i][8*b +: 8]]});
      else begin
        expq.push_back(words[i][15:0]);
        expq.push_back(words[i][31:16]);
      end
    end
    n = words.size() * (idx8 ? 4 : 2);
    first_acc = 0;
    fork
      foreach (words[i]) send_word(words[i]);
      begin
        wait (first_acc);
        repeat (n) begin pix_req = 1'b1; @(negedge clk); end
        pix_req = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    check("R6/R7 all pixels delivered", expq.size(), 0);
    check("R11 no underflow on steady stream", {31'b0, sts_und}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w [$];
    repeat (4) @(negedge clk);
    check("R1 in_ready", {31'b0, in_ready}, 0);
    check("R1 pix_valid", {31'b0, pix_valid}, 0);
    check("R1 status", {29'b0, sts_loaded, sts_err, sts_und}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;

    // palette only, 8 bpp: 128 words
    restart(2'b01);
    load_pal(3'd3, 11, 128, "R3 code3");
    @(negedge clk);
    check("R2 palette-only stops", {31'b0, in_ready}, 0);
    clr_loaded = 1'b1; @(negedge clk); clr_loaded = 1'b0;
    check("R9 w1c clears in palette-only", {31'b0, sts_loaded}, 0);
    check("R12 irq drops", {31'b0, irq}, 0);

    // frame only, 8 bpp expansion using the table
    restart(2'b10);
    check("R2 frame-only ready", {31'b0, in_ready}, 1);
    w = '{32'h8001ff00, 32'h12345678, 32'h00ff0100, 32'hfedcba98, 32'h7f80c3a5, 32'h01020304};
    stream(w, 1'b1); // R5 R6

    // underflow, then disable
    pix_req = 1'b1; @(negedge clk); pix_req = 1'b0;
    check("R11 underflow set", {31'b0, sts_und}, 1);
    @(negedge clk);
    check("R11 underflow sticky", {31'b0, sts_und}, 1);
    ctl_en = 1'b0; @(negedge clk);
    check("R10 disable clears und", {31'b0, sts_und}, 0);
    check("R10 disable idles", {31'b0, in_ready}, 0);

    // palette then frame, 16 bpp code
    restart(2'b00);
    load_pal(3'd4, 200, 8, "R3 code4");
    clr_loaded = 1'b1; @(negedge clk); clr_loaded = 1'b0;
    check("R9 w1c ignored in combined mode", {31'b0, sts_loaded}, 1);
    check("R2 combined moves to frame", {31'b0, in_ready}, 1);
    w = '{32'hbeef1234, 32'h0000ffff, 32'h5a5aa5a5, 32'h00010002, 32'hcafe0042};
    stream(w, 1'b0); // R7
    ctl_en = 1'b0; @(negedge clk);
    check("R10 disable clears loaded", {31'b0, sts_loaded}, 0);

    // small-depth code: 64 words
    restart(2'b01);
    load_pal(3'd0, 77, 64, "R3 code0");

    // bad depth code
    restart(2'b01);
    send_word(32'h0000_6abc);
    check("R4 error set", {31'b0, sts_err}, 1);
    check("R4 not loaded", {31'b0, sts_loaded}, 0);
    check("R4 stalls", {31'b0, in_ready}, 0);
    check("R12 irq on error", {31'b0, irq}, 1);
    ctl_en = 1'b0; @(negedge clk);
    check("R10 disable clears err", {31'b0, sts_err}, 0);

    // reserved mode
    restart(2'b11);
    repeat (2) @(negedge clk);
    check("R2 reserved mode idle", {31'b0, in_ready}, 0);

    // frame-only with depth code 0 latched: raw halves
    restart(2'b10);
    w = '{32'h11112222, 32'h33334444};
    stream(w, 1'b0); // R7

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule